// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block brings an asynchronous DRAM out of power-up and then keeps it refreshed. After reset it waits out a programmable pause, takes the memory bus from the access controller, and runs a burst of CAS-before-RAS (CBR) refresh cycles. When that burst is finished it raises a sticky initialisation flag. The same flag is brought out as the host-side ready, so the host port stays not-ready until the memory can be used.

Once initialised, an interval timer marks each refresh slot. Every slot adds one owed refresh to a small saturating backlog. While the backlog is non-zero and the sequencer is idle, it raises a bus request. The access controller grants the bus when it is idle or has just closed a row. The sequencer then drives the row strobe, every byte-lane column strobe and write-enable itself, and performs as many CBR cycles as the backlog held at the moment of the grant. A closing precharge follows, and then the request is dropped. All timings are counted in clock cycles; the defaults assume a 100 MHz clock (200 µs pause, 15 µs interval, 60 ns strobe-low, 40 ns precharge).

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is applied and in the first cycle after it, `ras_n`, every bit of `cas_n` and `we_n` are 1; `bus_req`, `drive_en`, `init_done` and `host_ready` are 0.
- R2: `bus_req` stays 0 for the first PAUSE_CYC cycles after reset is released and becomes 1 in the cycle that follows.
- R3: The first granted burst contains exactly INIT_CYCLES CBR cycles. `init_done` rises in the cycle in which that burst releases the bus and never falls until the next reset. `host_ready` always equals `init_done`.
- R4: In each CBR cycle, all column strobes go low CAS_LEAD cycles before the row strobe falls. They stay low for the whole time the row strobe is low, and return high in the same cycle as the row strobe.
- R5: The row strobe is low for exactly RAS_ACT cycles per CBR cycle. Every fall of the row strobe is preceded by RAS_PRE cycles with all strobes high, counted from the first cycle of bus ownership. After the last cycle of a burst, RAS_PRE more all-high cycles pass before the bus is released.
- R6: `we_n` is 1 in every cycle, so no refresh cycle can be taken as a write.
- R7: From the cycle `init_done` rises, one refresh slot comes due every REF_INTERVAL cycles. When the sequencer is idle and owes at least one refresh, `bus_req` rises in the next cycle.
- R8: The count of owed refreshes saturates at MISS_MAX. A burst performs as many CBR cycles as were owed when the grant was taken. A slot that comes due during a burst is owed to the next burst.
- R9: `drive_en` is 1 from the cycle after the grant is taken until the burst's closing precharge ends. `bus_req` is held 1 over that whole time and falls together with `drive_en`. Neither strobe is ever low while `drive_en` is 0.
- R10: `bus_gnt` has no effect while `bus_req` is 0: `drive_en` stays 0 and the strobes stay high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_gnt | input | 1 | Bus grant from the access controller |
| bus_req | output | 1 | Request for the memory bus |
| drive_en | output | 1 | Sequencer owns and drives the DRAM strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | CAS_W | Column strobes, one per byte lane, active low |
| we_n | output | 1 | Write enable, active low (held high) |
| init_done | output | 1 | Power-up pause and initial refresh burst are complete |
| host_ready | output | 1 | Host port ready; low until `init_done` |

## Verification
The embedded assertions take it as given that a grant, once given while `bus_req` is high, stays high until the sequencer releases the request. The access controller must therefore never withdraw the bus in the middle of a burst. The stimulus models the controller as a responder with a programmable grant latency. After granting, it holds the grant until it sees the request fall, and only then clears it. The latency is varied from immediate to longer than several refresh slots, which drives the backlog to one, two and its saturation depth. In one phase the responder also raises the grant on alternate cycles while no request is pending, which is the case R10 allows.

// File: rtl/drf_pkg.sv
// Package: shared state type and width helpers for the refresh sequencer.
// Assumes: widths are derived from parameters of at least 1.
package drf_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE,   // power-up wait, bus untouched
        ST_REQ,     // requesting the bus
        ST_PRE,     // all strobes high ahead of a CBR cycle
        ST_LEAD,    // column strobes low, row strobe still high
        ST_ACT,     // row and column strobes low
        ST_TAIL,    // closing precharge before releasing the bus
        ST_IDLE     // initialised, nothing owed
    } seq_state_e;

    // bits needed to hold values 0 .. v-1
    function automatic int idx_w(input int v);
        return (v <= 2) ? 1 : $clog2(v);
    endfunction

    // bits needed to hold values 0 .. v
    function automatic int cnt_w(input int v);
        return (v <= 1) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/drf_down_timer.sv
// Module: free-running down counter that pulses once every PERIOD enabled cycles.
// Assumes: PERIOD >= 1; counter holds while en is low and restarts only on reset.
module drf_down_timer #(
    parameter int PERIOD = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    import drf_pkg::*;

    localparam int W = idx_w(PERIOD);
    localparam logic [W-1:0] RELOAD = W'(PERIOD - 1);

    logic [W-1:0] cnt_q;

    // Purpose: count enabled cycles down and reload after reaching zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RELOAD;
        end else if (en) begin
            cnt_q <= (cnt_q == '0) ? RELOAD : cnt_q - 1'b1;
        end
    end

    assign tick = en && (cnt_q == '0);

    assert_timer_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= RELOAD);

    assert_timer_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == RELOAD));

endmodule

// File: rtl/drf_backlog.sv
// Module: saturating count of refresh slots that have come due but not yet been run.
// Assumes: take clears the count of refreshes handed to a burst in the same cycle
//          that a new slot may arrive; the new slot is kept.
module drf_backlog #(
    parameter int DEPTH = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               tick,
    input  logic                               take,
    output logic [drf_pkg::cnt_w(DEPTH)-1:0]   owed
);
    import drf_pkg::*;

    localparam int CW = cnt_w(DEPTH);
    localparam logic [CW-1:0] CAP = CW'(DEPTH);

    logic [CW-1:0] base;
    logic [CW-1:0] nxt;

    // Purpose: clear on take, add one slot per tick, never exceed CAP.
    always_comb begin
        base = take ? '0 : owed;
        nxt  = (tick && (base != CAP)) ? base + 1'b1 : base;
    end

    // Purpose: register the owed-refresh count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed <= '0;
        end else begin
            owed <= nxt;
        end
    end

    assert_backlog_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        owed <= CAP);

    assert_backlog_grow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !take && (owed < CAP)) |=> (owed == $past(owed) + 1'b1));

    assert_backlog_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !take && (owed == CAP)) |=> (owed == CAP));

endmodule

// File: rtl/drf_cbr_ctrl.sv
// Module: state machine that owns the bus handshake and shapes the CBR strobes.
// Assumes: once bus_gnt is seen with bus_req high, the grant stays high until
//          bus_req falls; CAS_LEAD, RAS_PRE and RAS_ACT are all at least 1.
module drf_cbr_ctrl #(
    parameter int INIT_CYCLES = 8,
    parameter int RAS_PRE     = 4,
    parameter int CAS_LEAD    = 1,
    parameter int RAS_ACT     = 6,
    parameter int MISS_MAX    = 4,
    parameter int CAS_W       = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 pause_tick,
    input  logic [drf_pkg::cnt_w(MISS_MAX)-1:0]  owed,
    input  logic                                 bus_gnt,
    output logic                                 take,
    output logic                                 pausing,
    output logic                                 bus_req,
    output logic                                 drive_en,
    output logic                                 ras_n,
    output logic [CAS_W-1:0]                     cas_n,
    output logic                                 init_done
);
    import drf_pkg::*;

    localparam int MAXPH = (RAS_PRE > RAS_ACT) ?
                           ((RAS_PRE > CAS_LEAD) ? RAS_PRE : CAS_LEAD) :
                           ((RAS_ACT > CAS_LEAD) ? RAS_ACT : CAS_LEAD);
    localparam int TW    = idx_w(MAXPH);
    localparam int MAXB  = (INIT_CYCLES > MISS_MAX) ? INIT_CYCLES : MISS_MAX;
    localparam int BW    = cnt_w(MAXB);
    localparam logic [TW-1:0] T_PRE  = TW'(RAS_PRE - 1);
    localparam logic [TW-1:0] T_LEAD = TW'(CAS_LEAD - 1);
    localparam logic [TW-1:0] T_ACT  = TW'(RAS_ACT - 1);

    seq_state_e     state_q;
    logic [TW-1:0]  tcnt_q;
    logic [BW-1:0]  left_q;
    logic           done_q;
    logic           phase_end;

    assign phase_end = (tcnt_q == '0);
    assign take      = (state_q == ST_REQ) && bus_gnt && done_q;

    // Purpose: step through pause, request, per-cycle strobe phases and idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PAUSE;
            tcnt_q  <= '0;
            left_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_PAUSE: begin
                    if (pause_tick) state_q <= ST_REQ;
                end
                ST_REQ: begin
                    if (bus_gnt) begin
                        state_q <= ST_PRE;
                        tcnt_q  <= T_PRE;
                        left_q  <= done_q ? BW'(owed) : BW'(INIT_CYCLES);
                    end
                end
                ST_PRE: begin
                    if (phase_end) begin
                        state_q <= ST_LEAD;
                        tcnt_q  <= T_LEAD;
                    end else begin
                        tcnt_q  <= tcnt_q - 1'b1;
                    end
                end
                ST_LEAD: begin
                    if (phase_end) begin
                        state_q <= ST_ACT;
                        tcnt_q  <= T_ACT;
                    end else begin
                        tcnt_q  <= tcnt_q - 1'b1;
                    end
                end
                ST_ACT: begin
                    if (phase_end) begin
                        tcnt_q <= T_PRE;
                        if (left_q > 1) begin
                            state_q <= ST_PRE;
                            left_q  <= left_q - 1'b1;
                        end else begin
                            state_q <= ST_TAIL;
                            left_q  <= '0;
                        end
                    end else begin
                        tcnt_q <= tcnt_q - 1'b1;
                    end
                end
                ST_TAIL: begin
                    if (phase_end) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        tcnt_q  <= tcnt_q - 1'b1;
                    end
                end
                ST_IDLE: begin
                    if (owed != '0) state_q <= ST_REQ;
                end
                default: state_q <= ST_PAUSE;
            endcase
        end
    end

    // Purpose: decode bus ownership and strobe levels from the state.
    always_comb begin
        pausing   = (state_q == ST_PAUSE);
        drive_en  = (state_q == ST_PRE) || (state_q == ST_LEAD) ||
                    (state_q == ST_ACT) || (state_q == ST_TAIL);
        bus_req   = drive_en || (state_q == ST_REQ);
        ras_n     = (state_q != ST_ACT);
        cas_n     = {CAS_W{!((state_q == ST_LEAD) || (state_q == ST_ACT))}};
        init_done = done_q;
    end

    assert_cas_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(cas_n == '0));

    assert_cas_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> (cas_n == '0));

    assert_cas_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (cas_n == '1));

    assert_strobe_owned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || (cas_n != '1)) |-> drive_en);

    assert_drive_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> bus_req);

    assert_release_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_en) |-> ($past(ras_n) && (cas_n == '1) && init_done));

    assert_done_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(init_done));

    assert_quiet_pause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pausing |-> (!bus_req && !init_done));

    assert_owned_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(drive_en) && bus_gnt) |-> $past(bus_req && bus_gnt));

endmodule

// File: rtl/dram_refresh_seq.sv
// Module: top of the DRAM power-up and CBR refresh sequencer.
// Assumes: a 100 MHz clock for the default cycle counts; the access controller
//          holds bus_gnt high until bus_req falls once it has granted.
module dram_refresh_seq #(
    parameter int PAUSE_CYC    = 20000,
    parameter int INIT_CYCLES  = 8,
    parameter int REF_INTERVAL = 1500,
    parameter int MISS_MAX     = 4,
    parameter int RAS_PRE      = 4,
    parameter int CAS_LEAD     = 1,
    parameter int RAS_ACT      = 6,
    parameter int CAS_W        = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_gnt,
    output logic             bus_req,
    output logic             drive_en,
    output logic             ras_n,
    output logic [CAS_W-1:0] cas_n,
    output logic             we_n,
    output logic             init_done,
    output logic             host_ready
);
    import drf_pkg::*;

    localparam int OW = cnt_w(MISS_MAX);

    logic          pausing;
    logic          pause_tick;
    logic          slot_tick;
    logic          take;
    logic [OW-1:0] owed;

    drf_down_timer #(.PERIOD(PAUSE_CYC)) u_pause (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (pausing),
        .tick  (pause_tick)
    );

    drf_down_timer #(.PERIOD(REF_INTERVAL)) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (init_done),
        .tick  (slot_tick)
    );

    drf_backlog #(.DEPTH(MISS_MAX)) u_backlog (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (slot_tick),
        .take  (take),
        .owed  (owed)
    );

    drf_cbr_ctrl #(
        .INIT_CYCLES (INIT_CYCLES),
        .RAS_PRE     (RAS_PRE),
        .CAS_LEAD    (CAS_LEAD),
        .RAS_ACT     (RAS_ACT),
        .MISS_MAX    (MISS_MAX),
        .CAS_W       (CAS_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pause_tick (pause_tick),
        .owed       (owed),
        .bus_gnt    (bus_gnt),
        .take       (take),
        .pausing    (pausing),
        .bus_req    (bus_req),
        .drive_en   (drive_en),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .init_done  (init_done)
    );

    // Purpose: refresh cycles are never writes; host waits for initialisation.
    assign we_n       = 1'b1;
    assign host_ready = init_done;

    assert_slot_after_init_R7: assert property (@(posedge clk) disable iff (!rst_n)
        slot_tick |-> init_done);

    assert_ready_tracks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready == init_done);

endmodule

// File: tb/dram_refresh_seq_test.sv
// Bench: behavioural reference model (queue of expected strobe levels, integer
// counters) compared against the outputs on every clock.
module dram_refresh_seq_test;

    localparam int P_PAUSE = 40;
    localparam int P_INIT  = 8;
    localparam int P_REF   = 50;
    localparam int P_MISS  = 4;
    localparam int P_PRE   = 4;
    localparam int P_LEAD  = 1;
    localparam int P_ACT   = 6;
    localparam int P_CW    = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            bus_gnt;
    logic            bus_req;
    logic            drive_en;
    logic            ras_n;
    logic [P_CW-1:0] cas_n;
    logic            we_n;
    logic            init_done;
    logic            host_ready;

    always #4 clk = ~clk;

    dram_refresh_seq #(
        .PAUSE_CYC    (P_PAUSE),
        .INIT_CYCLES  (P_INIT),
        .REF_INTERVAL (P_REF),
        .MISS_MAX     (P_MISS),
        .RAS_PRE      (P_PRE),
        .CAS_LEAD     (P_LEAD),
        .RAS_ACT      (P_ACT),
        .CAS_W        (P_CW)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_gnt    (bus_gnt),
        .bus_req    (bus_req),
        .drive_en   (drive_en),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .init_done  (init_done),
        .host_ready (host_ready)
    );

    int checks = 0;
    int fails  = 0;

    // reference model state: 0 pause, 1 request, 2 own bus, 3 idle
    int         m_mode;
    int         m_pause;
    int         m_since;
    int         m_pend;
    bit         m_done;
    logic [1:0] m_q[$];      // {ras_n, cas_n} per expected cycle

    // grant responder settings
    int g_delay = 0;
    bit g_spur  = 0;
    bit compare_on = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    task automatic push_phase(input int n, input logic [1:0] lv);
        for (int i = 0; i < n; i++) m_q.push_back(lv);
    endtask

    // Reference model update at each rising edge
    always @(posedge clk) begin : ref_model
        bit tick;
        bit grab;
        int n;
        int base;
        if (!rst_n) begin
            m_mode = 0; m_pause = 0; m_since = 0; m_pend = 0; m_done = 0;
            m_q.delete();
        end else begin
            tick = m_done && ((m_since % P_REF) == P_REF - 1);
            grab = (m_mode == 1) && bus_gnt && m_done;
            if (m_done) m_since++;
            case (m_mode)
                0: if (m_pause == P_PAUSE - 1) m_mode = 1; else m_pause++;
                1: if (bus_gnt) begin
                       n = m_done ? m_pend : P_INIT;
                       for (int c = 0; c < n; c++) begin
                           push_phase(P_PRE,  2'b11);
                           push_phase(P_LEAD, 2'b10);
                           push_phase(P_ACT,  2'b00);
                       end
                       push_phase(P_PRE, 2'b11);
                       m_mode = 2;
                   end
                2: begin
                       void'(m_q.pop_front());
                       if (m_q.size() == 0) begin
                           m_mode = 3;
                           m_done = 1;
                       end
                   end
                default: if (m_pend > 0) m_mode = 1;
            endcase
            base = grab ? 0 : m_pend;
            m_pend = (tick && base < P_MISS) ? base + 1 : base;
        end
    end

    // Per-cycle comparison, monitors and grant responder on the falling edge
    int  ras_falls_init = 0;
    bit  init_counted   = 0;
    int  burst_falls    = 0;
    int  max_burst      = 0;
    int  spur_idle      = 0;
    int  wait_c         = 0;
    logic prev_ras      = 1'b1;
    logic prev_drv      = 1'b0;
    logic prev_done     = 1'b0;

    initial begin : cmp_and_drive
        bit  e_own;
        logic [1:0] lv;
        forever begin
            @(negedge clk);
            if (compare_on) begin
                e_own = (m_mode == 2);
                lv    = e_own ? m_q[0] : 2'b11;
                chk("R2 R7 R8 bus_req", 32'(bus_req), 32'((m_mode == 1) || e_own));
                chk("R9 drive_en",      32'(drive_en), 32'(e_own));
                chk("R4 R5 ras_n",      32'(ras_n), 32'(lv[1]));
                chk("R4 cas_n",         32'(cas_n), lv[0] ? 32'hF : 32'h0);
                chk("R6 we_n",          32'(we_n), 32'd1);
                chk("R3 init_done",     32'(init_done), 32'(m_done));
                chk("R3 host_ready",    32'(host_ready), 32'(m_done));
                // R10: grant without request must leave the bus alone
                if (rst_n && bus_gnt && !bus_req && !prev_drv) begin
                    spur_idle++;
                    chk("R10 drive_en idle grant", 32'(drive_en), 32'd0);
                    chk("R10 ras_n idle grant",    32'(ras_n), 32'd1);
                end
                // R3: count CBR cycles before init_done
                if (prev_ras && !ras_n && !init_done) ras_falls_init++;
                if (init_done && !prev_done && !init_counted) begin
                    init_counted = 1;
                    chk("R3 init cycle count", 32'(ras_falls_init), 32'(P_INIT));
                end
                // R8: burst length after initialisation
                if (init_done && prev_ras && !ras_n) burst_falls++;
                if (prev_drv && !drive_en && init_done && prev_done) begin
                    if (burst_falls > max_burst) max_burst = burst_falls;
                    burst_falls = 0;
                end
            end
            prev_ras  = ras_n;
            prev_drv  = drive_en;
            prev_done = init_done;
            // grant responder
            if (!rst_n) begin
                bus_gnt = 1'b0;
                wait_c  = 0;
            end else if (bus_req) begin
                if (!bus_gnt) begin
                    if (wait_c >= g_delay) bus_gnt = 1'b1;
                    else wait_c++;
                end
            end else begin
                wait_c  = 0;
                bus_gnt = g_spur ? ~bus_gnt : 1'b0;
            end
        end
    end

    task automatic reset_check(input int cyc);
        rst_n = 1'b0;
        repeat (cyc) @(negedge clk);
        chk("R1 ras_n reset",      32'(ras_n), 32'd1);
        chk("R1 cas_n reset",      32'(cas_n), 32'hF);
        chk("R1 we_n reset",       32'(we_n), 32'd1);
        chk("R1 bus_req reset",    32'(bus_req), 32'd0);
        chk("R1 drive_en reset",   32'(drive_en), 32'd0);
        chk("R1 init_done reset",  32'(init_done), 32'd0);
        chk("R1 host_ready reset", 32'(host_ready), 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin : main
        rst_n   = 1'b0;
        bus_gnt = 1'b0;
        @(negedge clk);
        compare_on = 1;
        reset_check(3);
        // initialisation with a short grant latency, then single refreshes
        g_delay = 3;
        repeat (400) @(negedge clk);
        chk("R3 init reached", 32'(init_done), 32'd1);
        // long latency: backlog saturates at MISS_MAX
        g_delay = 230;
        repeat (700) @(negedge clk);
        g_delay = 70;
        repeat (400) @(negedge clk);
        // grants offered while nothing is requested
        g_delay = 0;
        g_spur  = 1;
        repeat (300) @(negedge clk);
        g_spur  = 0;
        chk("R8 saturated burst length", 32'(max_burst), 32'(P_MISS));
        chk("R10 idle grants seen", 32'(spur_idle > 0), 32'd1);
        // second reset mid-run, then a fresh initialisation
        init_counted   = 0;
        ras_falls_init = 0;
        reset_check(2);
        repeat (250) @(negedge clk);
        chk("R3 re-init reached", 32'(init_done), 32'd1);
        finish_run();
    end

endmodule